// File: doc/BRIEF.md
# Prioritising Interrupt Controller with Test-Gated Injection

The block gathers fifteen interrupt request lines, numbered 1 to 15, into a pending register and offers the processor one request at a time. Each line passes through a two-flip-flop synchroniser. A per-line shape bit then selects how the request is captured: a bit of 1 latches only a rising edge, and a bit of 0 latches the active-high level. Among the sources that are both pending and unmasked, the one with the highest number wins. The block drives its number as a 4-bit level, together with a trap type of 0x10 plus that number. When the processor acknowledges a level, the pending bit of that source is cleared.

Software reaches the registers through a word-addressed bus. Reads are combinational while the bus select is high. Writes take effect at the clock edge where select and write enable are both high. Bit n of every interrupt register belongs to source n, and bit 0 is always zero. There are six registers: shape at 0x44, pending at 0x48 (read only), mask at 0x4C, clear at 0x50, force at 0x54 and test control at 0xD0. The clear and force registers accept writes only and read back as zero. Writes to the force register inject requests only while bit 19 of test control is set.

Top module: `irqc_top`

## Requirements
- R1: A synchronous active-high reset gives: pending 0, mask 0x0000FFFE (every source disabled), shape 0, test control 0, level 0 and trap 0.
- R2: With the source's shape bit at 0, an input held high sets its pending bit on the third rising clock edge after the input changes. While the input stays high, a clear write does not remove that bit.
- R3: With the shape bit at 1, only a rising edge of the synchronised input sets the pending bit. After the bit is cleared, it stays clear while the input remains high.
- R4: The pending register (0x48) shows captured requests whether or not they are masked, and writes to it change nothing.
- R5: A write to the clear register (0x50) clears every pending bit that is 1 in the written word. The clear register reads 0.
- R6: A write to the force register (0x54) sets the pending bits that are 1 in the written word, but only while test control (0xD0) bit 19 is 1. At any other time the write has no effect. Test control reads back bit 19 alone, and the force register reads 0.
- R7: The level output is the highest source number that is both pending and unmasked, or 0 when no such source exists.
- R8: The trap output is 0x10 plus the level when the level is nonzero, and 0x00 otherwise.
- R9: An acknowledge with a nonzero ack level n clears pending bit n at that edge. If a capture or force sets bit n in the same cycle, the bit stays set.
- R10: Bit 0 is unused: it reads 0 in the pending, mask and shape registers, and input 0 and force bit 0 are ignored.
- R11: The mask register (0x4C) is read-write. A mask bit of 1 keeps its source out of prioritisation, and a bit of 0 lets it in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_src | input | 16 | Request lines, bit n is source n, bit 0 ignored |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| irq_level | output | 4 | Winning source number, 0 when none |
| irq_trap | output | 8 | Trap type for the winning source |
| irq_ack | input | 1 | Acknowledge strobe |
| ack_level | input | 4 | Source number being acknowledged |

## Verification
A wrong pending bit shows at the ports in one of two ways. A pending read returns it at once, in the same cycle. The level and trap outputs also reflect it combinationally, in the cycle after the edge that stored it. Corruption of the mask or shape state shows up on level and trap in the cycle after the write or capture that exposes it. The stimulus therefore reads every register back, and it samples level and trap right after each change of the request lines, the masks, the acknowledges and the forces.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC          = 15;
    localparam int IDW           = $clog2(NSRC + 1);
    localparam int DW            = 32;
    localparam int AW            = 8;
    localparam int SYNC_STAGES   = 2;
    localparam int TEST_GATE_BIT = 19;

    localparam logic [AW-1:0] OFS_SHAPE = 8'h44;
    localparam logic [AW-1:0] OFS_PEND  = 8'h48;
    localparam logic [AW-1:0] OFS_MASK  = 8'h4C;
    localparam logic [AW-1:0] OFS_CLEAR = 8'h50;
    localparam logic [AW-1:0] OFS_FORCE = 8'h54;
    localparam logic [AW-1:0] OFS_TEST  = 8'hD0;

    localparam logic [7:0] TRAP_BASE = 8'h10;

    typedef logic [NSRC:0] src_vec_t;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_SHAPE,
        REG_PEND,
        REG_MASK,
        REG_CLEAR,
        REG_FORCE,
        REG_TEST
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        case (a)
            OFS_SHAPE: return REG_SHAPE;
            OFS_PEND:  return REG_PEND;
            OFS_MASK:  return REG_MASK;
            OFS_CLEAR: return REG_CLEAR;
            OFS_FORCE: return REG_FORCE;
            OFS_TEST:  return REG_TEST;
            default:   return REG_NONE;
        endcase
    endfunction

    function automatic logic [7:0] trap_of(input logic [IDW-1:0] lvl);
        return (lvl == '0) ? 8'h00 : (TRAP_BASE + 8'(lvl));
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
    import irqc_pkg::*;
#(
    parameter int N      = NSRC,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N:0]   src,
    input  logic [N:0]   shape,
    output logic [N:0]   hit
);

    assign hit[0] = 1'b0;

    logic unused_bits;
    assign unused_bits = src[0] ^ shape[0];

    for (genvar i = 1; i <= N; i++) begin : g_src
        logic [STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-1:0], src[i]};
        end
        // sync is the settled sample, prev the one before it
        logic sync_q, prev_q;
        assign sync_q = chain[STAGES-1];
        assign prev_q = chain[STAGES];
        assign hit[i] = shape[i] ? (sync_q & ~prev_q) : sync_q;
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N    = NSRC,
    parameter int W    = DW,
    parameter int GATE = TEST_GATE_BIT,
    localparam int LW  = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  bus_req_t       req,
    input  logic [N:0]     hit,
    input  logic           ack,
    input  logic [LW-1:0]  ack_lvl,
    output logic [N:0]     pending,
    output logic [N:0]     mask,
    output logic [N:0]     shape,
    output logic [W-1:0]   rdata
);

    logic          test_en;
    logic [N:0]    wr_bits;
    logic [N:0]    frc_vec, clr_vec, ack_vec, set_vec, pend_d;
    logic          frc_wr;
    localparam logic [N:0] NO_BIT0 = {{N{1'b1}}, 1'b0};

    assign wr_bits = req.data[N:0] & NO_BIT0;
    assign frc_wr  = req.wr && req.sel == REG_FORCE;
    assign frc_vec = (frc_wr && test_en) ? wr_bits : '0;
    assign ack_vec = ack ? ((N+1)'(1) << ack_lvl) : '0;
    assign clr_vec = ((req.wr && req.sel == REG_CLEAR) ? wr_bits : '0) | ack_vec;
    assign set_vec = (hit | frc_vec) & NO_BIT0;
    // a set in the same cycle overrides any clear
    assign pend_d  = ((pending & ~clr_vec) | set_vec) & NO_BIT0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            mask    <= NO_BIT0;
            shape   <= '0;
            test_en <= 1'b0;
        end else begin
            pending <= pend_d;
            if (req.wr && req.sel == REG_MASK)  mask    <= wr_bits;
            if (req.wr && req.sel == REG_SHAPE) shape   <= wr_bits;
            if (req.wr && req.sel == REG_TEST)  test_en <= req.data[GATE];
        end
    end

    always_comb begin
        case (req.sel)
            REG_SHAPE: rdata = W'(shape);
            REG_PEND:  rdata = W'(pending);
            REG_MASK:  rdata = W'(mask);
            REG_TEST:  rdata = W'(test_en) << GATE;
            default:   rdata = '0;
        endcase
    end

    AST_FORCE_GATED: assert property (@(posedge clk) disable iff (rst)
        (|(pending & ~$past(pending) & ~$past(hit))) |-> $past(frc_wr && test_en)); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_lvl != '0 && !set_vec[ack_lvl]) |=> !pending[$past(ack_lvl)]); // R9

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int N   = NSRC,
    localparam int LW = $clog2(N + 1)
) (
    input  logic [N:0]    pending,
    input  logic [N:0]    mask,
    output logic [LW-1:0] level,
    output logic [7:0]    trap
);

    logic [N:0] active;
    assign active = pending & ~mask;

    always_comb begin
        level = '0;
        for (int i = 1; i <= N; i++) begin
            if (active[i]) level = LW'(i);
        end
    end

    assign trap = trap_of(level);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NSRC:0]  irq_src,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [IDW-1:0] irq_level,
    output logic [7:0]     irq_trap,
    input  logic           irq_ack,
    input  logic [IDW-1:0] ack_level
);

    bus_req_t  req;
    src_vec_t  hit, pending, mask, shape;
    logic [DW-1:0] reg_rdata;

    assign req.wr   = bus_sel & bus_we;
    assign req.sel  = bus_sel ? decode_addr(bus_addr) : REG_NONE;
    assign req.data = bus_wdata;

    irqc_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .src   (irq_src),
        .shape (shape),
        .hit   (hit)
    );

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .hit     (hit),
        .ack     (irq_ack),
        .ack_lvl (ack_level),
        .pending (pending),
        .mask    (mask),
        .shape   (shape),
        .rdata   (reg_rdata)
    );

    irqc_prio u_prio (
        .pending (pending),
        .mask    (mask),
        .level   (irq_level),
        .trap    (irq_trap)
    );

    assign bus_rdata = bus_sel ? reg_rdata : '0;

    AST_LEVEL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        irq_level != '0 |-> (pending[irq_level] && !mask[irq_level])); // R7

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (|(pending & ~mask)) |-> irq_level != '0); // R7

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_SRC = 3'd2;
    localparam logic [2:0] OP_LVL = 3'd3;
    localparam logic [2:0] OP_ACK = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t VECS [0:NV-1] = '{
        '{OP_RD,  8'h44, 32'h0,        32'h0,        4'd1},  // R1 shape
        '{OP_RD,  8'h48, 32'h0,        32'h0,        4'd1},  // R1 pending
        '{OP_RD,  8'h4C, 32'h0,        32'h0000FFFE, 4'd1},  // R1 mask
        '{OP_RD,  8'hD0, 32'h0,        32'h0,        4'd1},  // R1 test
        '{OP_LVL, 8'h00, 32'h0,        32'h0,        4'd1},  // R1 level/trap
        '{OP_WR,  8'h4C, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10
        '{OP_RD,  8'h4C, 32'h0,        32'h0000FFFE, 4'd10}, // R10 bit0 and upper bits
        '{OP_WR,  8'h4C, 32'h0,        32'h0,        4'd11}, // R11
        '{OP_RD,  8'h4C, 32'h0,        32'h0,        4'd11}, // R11
        '{OP_SRC, 8'h00, 32'h0011,     32'h0,        4'd2},  // R2 level src4, src0 ignored (R10)
        '{OP_RD,  8'h48, 32'h0,        32'h0010,     4'd2},  // R2
        '{OP_LVL, 8'h00, 32'h0,        32'h144,      4'd8},  // R8 trap 0x14
        '{OP_WR,  8'h50, 32'h0010,     32'h0,        4'd2},  // R2 clear while high
        '{OP_RD,  8'h48, 32'h0,        32'h0010,     4'd2},  // R2 still set
        '{OP_RD,  8'h50, 32'h0,        32'h0,        4'd5},  // R5 clear reads 0
        '{OP_SRC, 8'h00, 32'h0,        32'h0,        4'd2},  // R2 drop input
        '{OP_WR,  8'h50, 32'h0010,     32'h0,        4'd5},  // R5
        '{OP_RD,  8'h48, 32'h0,        32'h0,        4'd5},  // R5
        '{OP_LVL, 8'h00, 32'h0,        32'h0,        4'd7},  // R7 none pending
        '{OP_WR,  8'h44, 32'h2000,     32'h0,        4'd3},  // R3 edge on src13
        '{OP_RD,  8'h44, 32'h0,        32'h2000,     4'd3},  // R3
        '{OP_SRC, 8'h00, 32'h2000,     32'h0,        4'd3},  // R3
        '{OP_RD,  8'h48, 32'h0,        32'h2000,     4'd3},  // R3
        '{OP_WR,  8'h50, 32'h2000,     32'h0,        4'd3},  // R3
        '{OP_RD,  8'h48, 32'h0,        32'h0,        4'd3},  // R3 stays clear while high
        '{OP_WR,  8'h4C, 32'h2000,     32'h0,        4'd11}, // R11 mask src13
        '{OP_SRC, 8'h00, 32'h0,        32'h0,        4'd3},  // R3
        '{OP_SRC, 8'h00, 32'h2000,     32'h0,        4'd3},  // R3 new edge
        '{OP_LVL, 8'h00, 32'h0,        32'h0,        4'd11}, // R11 masked
        '{OP_RD,  8'h48, 32'h0,        32'h2000,     4'd4},  // R4 masked shown
        '{OP_WR,  8'h48, 32'h0,        32'h0,        4'd4},  // R4 write ignored
        '{OP_RD,  8'h48, 32'h0,        32'h2000,     4'd4},  // R4
        '{OP_SRC, 8'h00, 32'hA020,     32'h0,        4'd7},  // R7 src5, src15 level
        '{OP_RD,  8'h48, 32'h0,        32'hA020,     4'd7},  // R7
        '{OP_LVL, 8'h00, 32'h0,        32'h1FF,      4'd7},  // R7 15 wins
        '{OP_WR,  8'h4C, 32'hA000,     32'h0,        4'd7},  // R7
        '{OP_LVL, 8'h00, 32'h0,        32'h155,      4'd8},  // R8 level 5
        '{OP_WR,  8'h4C, 32'h0,        32'h0,        4'd7},  // R7
        '{OP_LVL, 8'h00, 32'h0,        32'h1FF,      4'd7},  // R7
        '{OP_ACK, 8'h00, 32'd13,       32'h0,        4'd9},  // R9
        '{OP_RD,  8'h48, 32'h0,        32'h8020,     4'd9},  // R9
        '{OP_ACK, 8'h00, 32'd15,       32'h0,        4'd9},  // R9 level still high
        '{OP_RD,  8'h48, 32'h0,        32'h8020,     4'd9},  // R9 set wins
        '{OP_SRC, 8'h00, 32'h0,        32'h0,        4'd9},  // R9
        '{OP_ACK, 8'h00, 32'd15,       32'h0,        4'd9},  // R9
        '{OP_RD,  8'h48, 32'h0,        32'h0020,     4'd9},  // R9
        '{OP_LVL, 8'h00, 32'h0,        32'h155,      4'd9},  // R9
        '{OP_ACK, 8'h00, 32'd5,        32'h0,        4'd9},  // R9
        '{OP_RD,  8'h48, 32'h0,        32'h0,        4'd9},  // R9
        '{OP_WR,  8'h54, 32'h0100,     32'h0,        4'd6},  // R6 gate closed
        '{OP_RD,  8'h48, 32'h0,        32'h0,        4'd6},  // R6
        '{OP_RD,  8'h54, 32'h0,        32'h0,        4'd6},  // R6 force reads 0
        '{OP_WR,  8'hD0, 32'hFFFFFFFF, 32'h0,        4'd6},  // R6 open gate
        '{OP_RD,  8'hD0, 32'h0,        32'h00080000, 4'd6},  // R6 bit 19 only
        '{OP_WR,  8'h54, 32'h0101,     32'h0,        4'd6},  // R6, bit0 ignored (R10)
        '{OP_RD,  8'h48, 32'h0,        32'h0100,     4'd6},  // R6
        '{OP_LVL, 8'h00, 32'h0,        32'h188,      4'd8},  // R8 trap 0x18
        '{OP_WR,  8'h50, 32'hFFFF,     32'h0,        4'd5},  // R5
        '{OP_RD,  8'h48, 32'h0,        32'h0,        4'd5},  // R5
        '{OP_LVL, 8'h00, 32'h0,        32'h0,        4'd7}   // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_level;
    logic [7:0]  irq_trap;
    logic        irq_ack = 1'b0;
    logic [3:0]  ack_level = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top dut (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (irq_src),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_level (irq_level),
        .irq_trap  (irq_trap),
        .irq_ack   (irq_ack),
        .ack_level (ack_level)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_ack(input logic [3:0] l);
        irq_ack = 1'b1; ack_level = l;
        @(posedge clk); #1;
        irq_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input int req, input string what);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp, what);
        bus_sel = 1'b0;
    endtask

    task automatic lvl_chk(input logic [11:0] exp, input int req, input string what);
        check(req, {20'h0, irq_trap, irq_level}, {20'h0, exp}, what);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                OP_WR:  do_write(VECS[v].addr, VECS[v].data);
                OP_ACK: do_ack(VECS[v].data[3:0]);
                OP_SRC: begin
                    irq_src = VECS[v].data[15:0];
                    repeat (3) @(posedge clk);
                    @(negedge clk);
                end
                OP_RD:  read_chk(VECS[v].addr, VECS[v].exp, int'(VECS[v].req), $sformatf("vector %0d read", v));
                default: lvl_chk(VECS[v].exp[11:0], int'(VECS[v].req), $sformatf("vector %0d trap/level", v));
            endcase
        end

        // R9: force setting bit 9 in the same cycle as its acknowledge keeps it
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h54; bus_wdata = 32'h0200;
        irq_ack = 1'b1; ack_level = 4'd9;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; irq_ack = 1'b0;
        @(negedge clk);
        read_chk(8'h48, 32'h0200, 9, "R9 force with ack same cycle");
        do_ack(4'd9);
        read_chk(8'h48, 32'h0, 9, "R9 ack alone");

        // R1: reset in mid-operation returns all state to its reset values
        do_write(8'h54, 32'h4000);
        do_write(8'h4C, 32'h1234);
        do_write(8'h44, 32'h00F0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_chk(8'h48, 32'h0, 1, "R1 pending after reset");
        read_chk(8'h4C, 32'h0000FFFE, 1, "R1 mask after reset");
        read_chk(8'h44, 32'h0, 1, "R1 shape after reset");
        read_chk(8'hD0, 32'h0, 1, "R1 test after reset");
        lvl_chk(12'h0, 1, "R1 level after reset");
        // R6: the gate is closed again after reset
        do_write(8'h54, 32'h4000);
        read_chk(8'h48, 32'h0, 6, "R6 force after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule